// File: doc/BRIEF.md
# Receive Sample Phase Tuning Engine

This block chooses the receive sampling phase for a card interface with no help from software. When it is started, it takes the phase now in use and steps through all eight settings of a 3-bit sample-select field. Before each probe it sends a one-cycle strobe that sets the data timeout to its largest value. It then asks an external command engine to send a probe, and waits for that engine's done and pass answer. Each phase that passes is recorded in an 8-bit candidate mask.

When the sweep has ended, the block looks for the best phase with a circular window search. It tests one rotation index per clock cycle. The search first looks for a phase whose two neighbours on each side also passed. If none exists, it looks for a phase whose nearest neighbours on both sides passed. If none exists, it takes the lowest passing phase. The chosen phase drives the sample-select output and is also kept as the tuned value. If no phase passed, an error flag is raised and the sample-select value is left as it was.

Top module: `phase_tune_top`

## Requirements
- R1: After reset, probeReq, tmoLoad, done and errFlag are 0, and samplePhase and tunedPhase are both 0.
- R2: A sweep started with curPhase = c probes the phases c+1, c+2, … in order, wrapping from 7 to 0. It ends with the probe at phase c, so it makes exactly 8 probes. samplePhase shows the phase under probe while probeReq is high.
- R3: tmoLoad is high for exactly the one cycle just before each cycle in which probeReq rises.
- R4: probeReq stays high until probeDone is seen. A probe answered with probePass = 1 marks the probed phase as a candidate.
- R5: The first selection pass chooses the lowest index i for which phases i-2 through i+2 (taken modulo 8) all passed.
- R6: If no such i exists, the lowest i for which phases i-1, i and i+1 (modulo 8) all passed is chosen.
- R7: If neither window matches, the lowest passing phase is chosen.
- R8: If no phase passed, errFlag is set together with done. samplePhase keeps the starting phase c, and tunedPhase keeps its earlier value.
- R9: On success, the chosen phase appears on both samplePhase and tunedPhase by the cycle in which done is high.
- R10: done is high for a single cycle at the end of each sweep. errFlag stays set until the next accepted start, which clears it.
- R11: A startReq that arrives while a sweep is in progress has no effect: the sweep still makes exactly 8 probes and gives the same result.
- R12: The candidate mask is cleared when a sweep is accepted, so passes from an earlier sweep do not affect the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start strobe; taken only when idle |
| curPhase | input | 3 | Phase in use when the sweep starts |
| probeReq | output | 1 | Request to the command engine to send a probe |
| probeDone | input | 1 | Command engine has finished the probe |
| probePass | input | 1 | Probe result, read while probeDone is high |
| tmoLoad | output | 1 | Strobe that sets the data timeout to all ones |
| samplePhase | output | 3 | Value that drives the sample-select field |
| tunedPhase | output | 3 | Tuned phase kept after the last successful sweep |
| done | output | 1 | One-cycle end-of-sweep pulse |
| errFlag | output | 1 | No phase passed in the last sweep |

## Verification
Timing is counted from the edge at which startReq is taken:
- tmoLoad comes in the next cycle, and probeReq in the cycle after that.
- Each probeDone leads to the next tmoLoad in the following cycle.
- The final probeDone leads to a selection that takes 1 to 24 cycles, one index per cycle, followed by a done cycle.

The bench drives inputs and samples outputs on the falling edge. It follows the request and answer exchange cycle by cycle, so it checks the probe order, the timeout strobe and how long the request is held as each probe happens. It then waits for done within a bounded window. It reads the result in the done cycle, and checks that done has fallen one cycle later. The expected phase comes from a separate window-search model run on the same pass pattern.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TLOAD,
    ST_PROBE,
    ST_SEL,
    ST_DONE
  } tuneState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // accept start: clear mask, seed phases
    logic rec;       // record probe result
    logic step;      // advance probe phase
    logic selInit;   // begin selection
    logic selNext;   // next rotation index
    logic selLevel;  // next (narrower) window level
    logic apply;     // apply chosen index
  } tuneCmd_t;
endpackage

// File: rtl/phase_tune_ctrl.sv
module phase_tune_ctrl
  import phase_tune_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     probeDone,
  input  logic     atStart,
  input  logic     hit,
  input  logic     lastIdx,
  input  logic     lastLevel,
  output tuneCmd_t cmd,
  output logic     tmoLoad,
  output logic     probeReq,
  output logic     done,
  output logic     errFlag
);
  tuneState_t state, stateNxt;
  logic errSet;

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    errSet   = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        cmd.load = 1'b1;
        stateNxt = ST_TLOAD;
      end
      ST_TLOAD: stateNxt = ST_PROBE;
      ST_PROBE: if (probeDone) begin
        cmd.rec = 1'b1;
        if (atStart) begin
          cmd.selInit = 1'b1;
          stateNxt    = ST_SEL;
        end else begin
          cmd.step = 1'b1;
          stateNxt = ST_TLOAD;
        end
      end
      ST_SEL: begin
        if (hit) begin
          cmd.apply = 1'b1;
          stateNxt  = ST_DONE;
        end else if (lastIdx) begin
          if (lastLevel) begin
            errSet   = 1'b1;
            stateNxt = ST_DONE;
          end else begin
            cmd.selLevel = 1'b1;
          end
        end else begin
          cmd.selNext = 1'b1;
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
    end else begin
      state <= stateNxt;
      if (cmd.load) errFlag <= 1'b0;
      else if (errSet) errFlag <= 1'b1;
    end
  end

  assign tmoLoad  = (state == ST_TLOAD);
  assign probeReq = (state == ST_PROBE);
  assign done     = (state == ST_DONE);
endmodule

// File: rtl/phase_tune_dp.sv
module phase_tune_dp
  import phase_tune_pkg::*;
#(
  parameter int PHASE_BITS  = 3,
  parameter int WIDE_HALF   = 2,
  parameter int NARROW_HALF = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tuneCmd_t              cmd,
  input  logic [PHASE_BITS-1:0] curPhase,
  input  logic                  probePass,
  output logic [PHASE_BITS-1:0] samplePhase,
  output logic [PHASE_BITS-1:0] tunedPhase,
  output logic                  atStart,
  output logic                  hit,
  output logic                  lastIdx,
  output logic                  lastLevel
);
  localparam int NPH = 1 << PHASE_BITS;
  localparam int LEVELS = 3;
  localparam int LVW = $clog2(LEVELS);

  // window around bit 0 covering +-half, wrapping at the top
  function automatic logic [NPH-1:0] winMask(input int half);
    logic [NPH-1:0] m;
    for (int j = 0; j < NPH; j++) m[j] = (j <= half) || (j >= NPH - half);
    return m;
  endfunction

  localparam logic [NPH-1:0] WIN_WIDE   = winMask(WIDE_HALF);
  localparam logic [NPH-1:0] WIN_NARROW = winMask(NARROW_HALF);
  localparam logic [NPH-1:0] WIN_ONE    = winMask(0);

  logic [NPH-1:0]        candMask;
  logic [PHASE_BITS-1:0] startPh;
  logic [PHASE_BITS-1:0] selIdx;
  logic [LVW-1:0]        selLvl;
  logic [2*NPH-1:0]      dblMask;
  logic [NPH-1:0]        rotMask;
  logic [NPH-1:0]        winSel;

  assign dblMask = {candMask, candMask} >> selIdx;
  assign rotMask = dblMask[NPH-1:0];

  always_comb begin
    unique case (selLvl)
      LVW'(0): winSel = WIN_WIDE;
      LVW'(1): winSel = WIN_NARROW;
      default: winSel = WIN_ONE;
    endcase
  end

  assign hit       = ((rotMask & winSel) == winSel);
  assign lastIdx   = (selIdx == PHASE_BITS'(NPH - 1));
  assign lastLevel = (selLvl == LVW'(LEVELS - 1));
  assign atStart   = (samplePhase == startPh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candMask    <= '0;
      startPh     <= '0;
      samplePhase <= '0;
      tunedPhase  <= '0;
      selIdx      <= '0;
      selLvl      <= '0;
    end else begin
      if (cmd.load) begin
        candMask    <= '0;
        startPh     <= curPhase;
        samplePhase <= curPhase + 1'b1;
      end
      if (cmd.rec && probePass) candMask[samplePhase] <= 1'b1;
      if (cmd.step) samplePhase <= samplePhase + 1'b1;
      if (cmd.selInit) begin
        selIdx <= '0;
        selLvl <= '0;
      end
      if (cmd.selNext) selIdx <= selIdx + 1'b1;
      if (cmd.selLevel) begin
        selIdx <= '0;
        selLvl <= selLvl + 1'b1;
      end
      if (cmd.apply) begin
        samplePhase <= selIdx;
        tunedPhase  <= selIdx;
      end
    end
  end
endmodule

// File: rtl/phase_tune_top.sv
module phase_tune_top
  import phase_tune_pkg::*;
#(
  parameter int PHASE_BITS  = 3,
  parameter int WIDE_HALF   = 2,
  parameter int NARROW_HALF = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic [PHASE_BITS-1:0] curPhase,
  output logic                  probeReq,
  input  logic                  probeDone,
  input  logic                  probePass,
  output logic                  tmoLoad,
  output logic [PHASE_BITS-1:0] samplePhase,
  output logic [PHASE_BITS-1:0] tunedPhase,
  output logic                  done,
  output logic                  errFlag
);
  tuneCmd_t cmd;
  logic atStart, hit, lastIdx, lastLevel;

  phase_tune_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .probeDone(probeDone),
    .atStart(atStart), .hit(hit), .lastIdx(lastIdx), .lastLevel(lastLevel),
    .cmd(cmd), .tmoLoad(tmoLoad), .probeReq(probeReq), .done(done),
    .errFlag(errFlag)
  );

  phase_tune_dp #(
    .PHASE_BITS(PHASE_BITS), .WIDE_HALF(WIDE_HALF), .NARROW_HALF(NARROW_HALF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .curPhase(curPhase),
    .probePass(probePass), .samplePhase(samplePhase), .tunedPhase(tunedPhase),
    .atStart(atStart), .hit(hit), .lastIdx(lastIdx), .lastLevel(lastLevel)
  );
endmodule

// File: rtl/phase_tune_chk.sv
module phase_tune_chk #(
  parameter int PB = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          probeReq,
  input logic          probeDone,
  input logic          tmoLoad,
  input logic [PB-1:0] samplePhase,
  input logic [PB-1:0] tunedPhase,
  input logic          done,
  input logic          errFlag
);
  p_tmo_before_probe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(probeReq) |-> $past(tmoLoad));

  p_probe_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    probeReq && !probeDone |=> probeReq);

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    tmoLoad && $past(probeReq) |-> samplePhase == PB'($past(samplePhase) + 1'b1));

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> done);

  p_pick_applied_r9: assert property (@(posedge clk) disable iff (!rstN)
    done && !errFlag |-> samplePhase == tunedPhase);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind phase_tune_top phase_tune_chk #(.PB(PHASE_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .probeReq(probeReq), .probeDone(probeDone),
  .tmoLoad(tmoLoad), .samplePhase(samplePhase), .tunedPhase(tunedPhase),
  .done(done), .errFlag(errFlag)
);

// File: tb/phase_tune_top_bench.sv
module phase_tune_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [2:0] curPhase = '0;
  logic probeDone = 1'b0;
  logic probePass = 1'b0;
  logic probeReq, tmoLoad, done, errFlag;
  logic [2:0] samplePhase, tunedPhase;

  int nChecks = 0;
  int nFails = 0;

  // results of the last sweep
  int  probes;
  bit  orderOk, tmoOk, holdOk, gotDone, gotErr, doneFell;
  logic [2:0] gotSample, gotTuned;

  always #10 clk = ~clk;

  phase_tune_top u_phase_tune_top (
    .clk(clk), .rstN(rstN), .startReq(startReq), .curPhase(curPhase),
    .probeReq(probeReq), .probeDone(probeDone), .probePass(probePass),
    .tmoLoad(tmoLoad), .samplePhase(samplePhase), .tunedPhase(tunedPhase),
    .done(done), .errFlag(errFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent window-search model
  function automatic int pickRef(input logic [7:0] m);
    int halves[3] = '{2, 1, 0};
    for (int lv = 0; lv < 3; lv++)
      for (int i = 0; i < 8; i++) begin
        bit ok = 1'b1;
        for (int d = -halves[lv]; d <= halves[lv]; d++)
          if (!m[(i + d + 8) % 8]) ok = 1'b0;
        if (ok) return i;
      end
    return -1;
  endfunction

  task automatic doSweep(input logic [2:0] cur, input logic [7:0] pm,
                         input int delay, input bit poke);
    logic [2:0] expPh;
    bit lastTmo;
    int cyc;
    @(negedge clk);
    curPhase = cur;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    probes = 0; orderOk = 1; tmoOk = 1; holdOk = 1; gotDone = 0; gotErr = 0;
    doneFell = 0;
    expPh = cur + 3'd1;
    lastTmo = tmoLoad;
    cyc = 0;
    while (cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (done) begin
        gotDone = 1; gotErr = errFlag; gotSample = samplePhase; gotTuned = tunedPhase;
        break;
      end
      if (probeReq) begin
        logic [2:0] ph;
        ph = samplePhase;
        if (ph != expPh) orderOk = 0;
        if (!lastTmo) tmoOk = 0;
        for (int k = 0; k < delay; k++) begin
          @(negedge clk);
          if (!probeReq) holdOk = 0;
        end
        probeDone = 1'b1;
        probePass = pm[ph];
        if (poke) startReq = 1'b1;
        @(negedge clk);
        probeDone = 1'b0;
        probePass = 1'b0;
        startReq = 1'b0;
        probes++;
        expPh = expPh + 3'd1;
      end
      lastTmo = tmoLoad;
    end
    @(negedge clk);
    doneFell = !done;
  endtask

  task automatic checkSweep(input string req, input logic [2:0] cur,
                            input logic [7:0] pm, input logic [2:0] prevTuned);
    int exp;
    exp = pickRef(pm);
    chk(gotDone, "R10 done seen", gotDone, 1);
    chk(doneFell, "R10 done one cycle", doneFell, 1);
    chk(probes == 8, "R2 probe count", probes, 8);
    chk(orderOk, "R2 probe order", orderOk, 1);
    chk(tmoOk, "R3 timeout strobe before probe", tmoOk, 1);
    if (exp < 0) begin
      chk(gotErr == 1, "R8 error flag", gotErr, 1);
      chk(gotSample == cur, "R8 sample kept", gotSample, cur);
      chk(gotTuned == prevTuned, "R8 tuned kept", gotTuned, prevTuned);
    end else begin
      chk(gotErr == 0, {req, " no error"}, gotErr, 0);
      chk(gotSample == exp, {req, " sample phase"}, gotSample, exp);
      chk(gotTuned == exp, "R9 tuned phase", gotTuned, exp);
    end
  endtask

  task automatic testReset;
    @(negedge clk);
    chk(!probeReq && !tmoLoad && !done && !errFlag, "R1 idle outputs",
        {probeReq, tmoLoad, done, errFlag}, 0);
    chk(samplePhase == 0 && tunedPhase == 0, "R1 phases zero",
        {samplePhase, tunedPhase}, 0);
  endtask

  task automatic testWide;
    doSweep(3'd3, 8'hFF, 0, 0);  checkSweep("R5 all pass", 3'd3, 8'hFF, 3'd0);
    doSweep(3'd0, 8'h3E, 0, 0);  checkSweep("R5 centre", 3'd0, 8'h3E, 3'd0);
    doSweep(3'd5, 8'hC7, 0, 0);  checkSweep("R5 wrap", 3'd5, 8'hC7, 3'd3);
  endtask

  task automatic testNarrow;
    doSweep(3'd2, 8'h70, 2, 0);
    checkSweep("R6 narrow", 3'd2, 8'h70, 3'd0);
    chk(holdOk, "R4 request held", holdOk, 1);
    doSweep(3'd7, 8'hC1, 0, 0);  checkSweep("R6 narrow wrap", 3'd7, 8'hC1, 3'd5);
  endtask

  task automatic testSingleAndEmpty;
    doSweep(3'd4, 8'h24, 0, 0);  checkSweep("R7 lowest pass", 3'd4, 8'h24, 3'd7);
    // R12: earlier sweep had passes; an all-fail sweep must still error
    doSweep(3'd6, 8'h00, 0, 0);  checkSweep("R12 mask cleared", 3'd6, 8'h00, 3'd2);
    @(negedge clk);
    chk(errFlag == 1, "R10 error held", errFlag, 1);
    doSweep(3'd1, 8'h10, 0, 0);  checkSweep("R10 error cleared", 3'd1, 8'h10, 3'd2);
  endtask

  task automatic testBusyStart;
    doSweep(3'd1, 8'h1C, 1, 1);
    checkSweep("R11 start ignored", 3'd1, 8'h1C, 3'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWide();
    testNarrow();
    testSingleAndEmpty();
    testBusyStart();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule